// File: doc/BRIEF.md
# Two-Phase Result Byte Formatter

This block takes 14-bit conversion results and shows each one on a narrow 8-bit output bus over two launch periods. The first period carries the upper part of the result. The second carries the remaining bits, placed at the top of the bus with zero fill underneath. A phase flag is high only while the upper part is on the bus, so a receiver can pair the two bytes and rebuild the word.

A result is captured on the rising master-clock edge when its valid strobe is high. A configuration input picks the launch edge. With the input at 1, the bus and the phase flag change on the rising edge. With it at 0, they change on the following falling edge, half a period later. Widths are parameters. The falling-edge path can be left out at build time, and the block then launches on the rising edge only.

Top module: `result_byte_fmt`

## Requirements
- R1: In the first phase the bus carries result bits 13..6 on bus bits 7..0, and the phase flag is 1.
- R2: On the launch edge after the first phase, the bus carries result bits 5..0 on bus bits 7..2, and the phase flag is 0.
- R3: While the phase flag is 0, bus bits 1..0 are 0.
- R4: With edge select at 1, a new bus value and phase flag appear at the rising master-clock edge that follows the capturing edge.
- R5: With edge select at 0, the new value appears at the next falling edge. Between that rising edge and that falling edge, the bus still shows the previous value.
- R6: The phase flag is high for exactly one launch period for each accepted result. The upper part always precedes the lower part.
- R7: A valid strobe seen while the phase flag is 1 is ignored. The lower part of the result already in progress follows unchanged.
- R8: A valid strobe seen while the phase flag is 0 is accepted, and its upper part launches on the next launch edge.
- R9: During reset, and after reset until the first accepted result, the bus is 0 and the phase flag is 0.
- R10: With no valid strobe while the phase flag is 0, the bus holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_i | input | 14 | Conversion result |
| res_vld_i | input | 1 | Result valid strobe, sampled on the rising edge |
| edge_sel_i | input | 1 | Launch edge: 1 = rising, 0 = falling |
| bus_o | output | 8 | Formatted output byte |
| phase_hi_o | output | 1 | 1 while the upper part is on the bus |

## Verification
Results are sent with all ones, alternating bit patterns and walking single ones. These show that every result bit lands on its own bus bit and that the pad bits stay zero. Strobes are sent isolated, on every other cycle and on every cycle. Together these separate acceptance during the low phase from rejection during the high phase. Each pattern runs under both edge-select values. The bus is sampled a quarter period after the rising edge and again after the falling edge, so rising-edge launch and falling-edge launch give different results.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

   // Which part of a result is on the bus
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

endpackage

// File: rtl/fmt_split.sv
// Rising-edge core: accepts results and steps through the high and low parts.
module fmt_split #(
   parameter int RES_W = 14,
   parameter int BUS_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [RES_W-1:0] res_i,
   input  logic             res_vld_i,
   output logic [BUS_W-1:0] bus_o,
   output logic             phase_o
);
   import fmt_pkg::*;

   localparam int LO_W  = RES_W - BUS_W;
   localparam int PAD_W = BUS_W - LO_W;

   phase_e           ph_q;
   logic [BUS_W-1:0] bus_q;
   logic [LO_W-1:0]  lo_q;
   logic             take;
   logic [BUS_W-1:0] lo_bus;

   assign take   = res_vld_i && (ph_q == PH_LOW);
   assign lo_bus = {lo_q, {PAD_W{1'b0}}};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q  <= PH_LOW;
         bus_q <= '0;
         lo_q  <= '0;
      end else if (take) begin
         bus_q <= res_i[RES_W-1:LO_W];
         lo_q  <= res_i[LO_W-1:0];
         ph_q  <= PH_HIGH;
      end else if (ph_q == PH_HIGH) begin
         bus_q <= lo_bus;
         ph_q  <= PH_LOW;
      end
   end

   assign bus_o   = bus_q;
   assign phase_o = (ph_q == PH_HIGH);

   AST_HI_ONE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q == PH_HIGH) |=> (ph_q == PH_LOW)); // R6
   AST_HI_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ph_q == PH_HIGH) |-> (bus_q == $past(res_i[RES_W-1:LO_W]))); // R1
   AST_LO_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ph_q == PH_HIGH) |-> (bus_q[BUS_W-1:PAD_W] == $past(res_i[LO_W-1:0], 2))); // R2
   AST_LO_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ph_q == PH_HIGH) |-> (bus_q[PAD_W-1:0] == '0)); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ph_q == PH_LOW) && !res_vld_i) |=> $stable(bus_q)); // R10
   AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ph_q == PH_HIGH) && res_vld_i) |=> !$rose(ph_q == PH_HIGH)); // R7

endmodule

// File: rtl/fmt_launch.sv
// Output launch stage: picks the rising-edge value or a falling-edge retimed copy.
module fmt_launch #(
   parameter int W         = 9,
   parameter bit FALL_PATH = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         edge_sel_i,
   input  logic [W-1:0] rise_i,
   output logic [W-1:0] out_o
);
   generate
      if (FALL_PATH) begin : g_fall
         logic [W-1:0] fall_q;

         always_ff @(negedge clk_i or negedge rst_ni) begin
            if (!rst_ni) fall_q <= '0;
            else         fall_q <= rise_i;
         end

         assign out_o = edge_sel_i ? rise_i : fall_q;

         AST_FALL_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            fall_q == rise_i); // R5
      end else begin : g_rise_only
         logic unused_sel;
         assign unused_sel = edge_sel_i;
         assign out_o      = rise_i;
      end
   endgenerate

endmodule

// File: rtl/result_byte_fmt.sv
module result_byte_fmt #(
   parameter int RES_W     = 14,
   parameter int BUS_W     = 8,
   parameter bit FALL_PATH = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [RES_W-1:0] res_i,
   input  logic             res_vld_i,
   input  logic             edge_sel_i,
   output logic [BUS_W-1:0] bus_o,
   output logic             phase_hi_o
);
   localparam int LW = BUS_W + 1;

   initial begin
      AST_PARAMS: assert (RES_W > BUS_W && RES_W < 2 * BUS_W)
         else $error("result width must lie strictly between bus width and twice it");
   end

   logic [BUS_W-1:0] rise_bus;
   logic             rise_ph;
   logic [LW-1:0]    launched;

   fmt_split #(.RES_W(RES_W), .BUS_W(BUS_W)) u_split (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .res_i     (res_i),
      .res_vld_i (res_vld_i),
      .bus_o     (rise_bus),
      .phase_o   (rise_ph)
   );

   fmt_launch #(.W(LW), .FALL_PATH(FALL_PATH)) u_launch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .edge_sel_i (edge_sel_i),
      .rise_i     ({rise_ph, rise_bus}),
      .out_o      (launched)
   );

   assign phase_hi_o = launched[LW-1];
   assign bus_o      = launched[BUS_W-1:0];

   AST_RST_QUIET: assert property (@(posedge clk_i)
      !rst_ni |-> (bus_o == '0 && !phase_hi_o)); // R9

endmodule

// File: tb/tb_result_byte_fmt.sv
module tb_result_byte_fmt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] res = '0;
   logic        res_vld = 1'b0;
   logic        edge_sel = 1'b1;
   logic [7:0]  bus;
   logic        ph;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #10 clk = ~clk;

   result_byte_fmt dut (
      .clk_i(clk), .rst_ni(rst_n), .res_i(res), .res_vld_i(res_vld),
      .edge_sel_i(edge_sel), .bus_o(bus), .phase_hi_o(ph)
   );

   // behavioural reference
   logic [7:0] m_bus = '0;
   logic       m_ph  = 1'b0;
   logic [7:0] pend[$];
   logic [7:0] p_bus;
   logic       p_ph;
   bit         seen_result = 0;

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic step(input logic v, input logic [13:0] d, input logic s);
      res_vld  = v;
      res      = d;
      edge_sel = s;
      @(posedge clk);
      p_bus = m_bus;
      p_ph  = m_ph;
      if (!rst_n) begin
         m_bus = '0; m_ph = 1'b0; pend.delete();
      end else if (v && !m_ph) begin
         m_bus = d[13:6]; m_ph = 1'b1; pend.push_back({d[5:0], 2'b00});
         seen_result = 1;
      end else if (pend.size() > 0) begin
         m_bus = pend.pop_front(); m_ph = 1'b0;
      end
      #5;
      if (s) check("R4 rising launch", {ph, bus}, {m_ph, m_bus});
      else   check("R5 falling launch holds old", {ph, bus}, {p_ph, p_bus});
      #10;
      if (!rst_n || !seen_result)     check("R9 quiet", {ph, bus}, 9'h0);
      else if (m_ph)                  check("R1 high part", bus, m_bus);
      else if (p_ph)                  check("R2 low part", bus, m_bus);
      else                            check("R10 hold", bus, m_bus);
      check("R6 phase flag", ph, m_ph);
      if (!m_ph) check("R3 pad zero", bus[1:0], 0);
      #1;
   endtask

   initial begin : watchdog
      #(200000 * 20);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      #16;
      step(1'b1, 14'h3FFF, 1'b1);   // ignored in reset, R9
      step(1'b1, 14'h1234, 1'b0);
      rst_n = 1'b1;
      step(1'b0, 14'h3FFF, 1'b1);
      step(1'b0, 14'h0000, 1'b0);
      for (int s = 0; s < 2; s++) begin
         logic sel;
         sel = (s == 0);
         // isolated patterns
         step(1'b1, 14'h3FFF, sel); step(1'b0, 0, sel); step(1'b0, 0, sel);
         step(1'b1, 14'h2AAA, sel); step(1'b0, 0, sel); step(1'b0, 0, sel);
         step(1'b1, 14'h1555, sel); step(1'b0, 0, sel); step(1'b0, 0, sel);
         // walking ones
         for (int b = 0; b < 14; b++) begin
            step(1'b1, 14'(1 << b), sel);
            step(1'b0, 0, sel);
         end
         // R7: strobe during high phase ignored
         step(1'b1, 14'h2C3B, sel);
         step(1'b1, 14'h0F0F, sel);
         step(1'b0, 0, sel);
         check("R7 low of first result", bus, {6'h3B, 2'b00});
         step(1'b0, 0, sel);
         check("R10 hold low", bus, {6'h3B, 2'b00});
         // R8: accept while low on bus
         step(1'b1, 14'h1A5C, sel);
         step(1'b0, 0, sel);
         step(1'b1, 14'h3E01, sel);
         check("R8 accepted high", {ph, bus}, {1'b1, 8'hF8});
         step(1'b0, 0, sel);
         check("R8 accepted low", {ph, bus}, {1'b0, 8'h04});
         // strobes every cycle, then every other cycle
         for (int k = 0; k < 12; k++) step(1'b1, 14'(k * 1237 + 91), sel);
         for (int k = 0; k < 12; k++) step(k[0] == 1'b0, 14'(k * 613 + 7), sel);
      end
      // switch edge mid-stream
      for (int k = 0; k < 10; k++) step(1'b1, 14'(k * 999 + 5), k[1]);
      step(1'b0, 0, 1'b1);
      step(1'b0, 0, 1'b0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule